// File: doc/BRIEF.md
# Strided Layout Address Generator with XOR Swizzle

This block walks a logical coordinate space of up to four modes and produces one physical byte offset per accepted output beat. Each mode has a programmable extent and a programmable stride. The block keeps an odometer of coordinates, forms the affine element offset as the dot product of the coordinate vector with the stride vector, and scales that offset to bytes by a programmable element size. A separate stage then applies an optional XOR swizzle to the byte offset. Row-major, column-major, transposed and tiled views all come from the stride tuple alone. The swizzle is a non-affine transform that runs after the affine address and is never folded into the strides.

Software sets up the configuration inputs while the block is idle and then pulses `start`. The block latches the configuration on that pulse. It presents each offset together with the coordinate that produced it on a valid/ready output, moves to the next coordinate only on a handshake, and raises `done` once the final coordinate has been accepted. A typical use is to drive the address side of a shared-memory tile copy. There, a swizzle of eight 16-byte chunks over 128-byte lines lets both rows and columns of a 2-byte-element tile spread across all memory banks.

Top module: `layout_addr_gen`

## Requirements
- R1: While `out_valid` is high, `out_offset` equals ((sum over modes of coord[i] × stride[i]) shifted left by the element-size code), with the swizzle of R4 applied afterwards. All arithmetic is 32-bit unsigned and wraps. Element-size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R2: Mode 0 varies fastest. Each accepted beat increments mode 0. A mode that reaches extent−1 wraps to 0 and carries into the next higher mode, so the walk covers every coordinate exactly once in this nested order.
- R3: A mode with extent 1 stays at coordinate 0, and its stride has no effect on any offset. An extent of 0 is treated as 1.
- R4: The swizzle uses three fields: B (bits, 0..7), M (base position) and S (shift). Let F be the B-bit field at byte-offset bit position M+S. The output is the byte offset XOR (F << M). B = 0 leaves the offset unchanged.
- R5: The swizzle is applied to the scaled byte offset. It can change only bits M..M+B−1 of that offset.
- R6: The block moves to the next coordinate only on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_offset` and `out_coord` hold their values.
- R7: A `start` pulse while idle latches all configuration inputs. In the next cycle `out_valid` rises with every coordinate at 0.
- R8: After the handshake of the last coordinate, `out_valid` is low and `done` is high from the next cycle. `done` stays high until the next accepted `start`.
- R9: A `start` pulse during a walk is ignored. Changes on the configuration inputs during a walk have no effect on the walk in progress.
- R10: After reset, `out_valid` and `done` are low.
- R11: With extents (64, 8), strides (1, 64), 2-byte elements and swizzle B=3, M=4, S=3, the eight rows of any one column fall in eight distinct banks. A bank is (byte offset / 4) mod 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_extent | input | NMODES×CW | Extent of each mode; mode 0 is innermost |
| cfg_stride | input | NMODES×AW | Stride of each mode, in elements |
| cfg_esize | input | 2 | Element-size code: 0 = 1 B, 1 = 2 B, 2 or 3 = 4 B |
| cfg_swz_bits | input | 3 | Swizzle field width B; 0 disables the swizzle |
| cfg_swz_base | input | 5 | Swizzle target bit position M |
| cfg_swz_shift | input | 5 | Swizzle source distance S |
| start | input | 1 | Starts a walk when idle |
| out_valid | output | 1 | Offset and coordinate are presented |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_offset | output | AW | Swizzled byte offset |
| out_coord | output | NMODES×CW | Coordinate of the current beat |
| done | output | 1 | Last beat accepted; held until the next start |

## Verification
Some properties are checked by the assertions on every cycle:
- each coordinate stays below its latched extent;
- a stalled beat keeps its offset and coordinate;
- a walk always opens at the zero coordinate;
- `done` never coincides with `out_valid`;
- a start pulse during a walk leaves the latched configuration unchanged;
- the swizzle changes no bit outside its target field.

The remaining behaviour can be shown only by the bench's scenarios, which sweep complete walks against arithmetically computed offsets. This covers the nested visit order and carry chain, the inert and zero extents, and 32-bit wraparound. It also covers element scaling, the exact swizzle values, and the distinct-bank property of the column reads.

// File: rtl/layout_pkg.sv
package layout_pkg;

  typedef enum logic [1:0] {
    ESZ_1B = 2'd0,
    ESZ_2B = 2'd1,
    ESZ_4B = 2'd2,
    ESZ_4X = 2'd3
  } esize_e;

  typedef struct packed {
    logic [2:0] bits;
    logic [4:0] base;
    logic [4:0] shift;
  } swz_cfg_t;

  function automatic logic [1:0] esize_shamt(input logic [1:0] code);
    logic [1:0] r;
    case (code)
      ESZ_1B:  r = 2'd0;
      ESZ_2B:  r = 2'd1;
      default: r = 2'd2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/layout_odometer.sv
module layout_odometer #(
  parameter int NMODES = 4,
  parameter int CW     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic                        advance,
  input  logic [NMODES-1:0][CW-1:0]   extent,
  output logic [NMODES-1:0][CW-1:0]   coord,
  output logic                        busy,
  output logic                        last
);

  logic [NMODES-1:0][CW-1:0] coord_d;
  logic                      busy_d;
  logic [NMODES-1:0]         at_top;

  for (genvar g = 0; g < NMODES; g++) begin : g_top
    assign at_top[g] = (coord[g] == (extent[g] - 1'b1));
  end

  assign last = &at_top;

  always_comb begin
    logic carry;
    coord_d = coord;
    busy_d  = busy;
    carry   = advance;
    for (int i = 0; i < NMODES; i++) begin
      if (carry) begin
        if (at_top[i]) begin
          coord_d[i] = '0;
        end else begin
          coord_d[i] = coord[i] + 1'b1;
          carry      = 1'b0;
        end
      end
    end
    if (launch && !busy) begin
      busy_d  = 1'b1;
      coord_d = '0;
    end else if (advance && last) begin
      busy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      coord <= '0;
    end else begin
      if ((launch && !busy) || advance) begin
        coord <= coord_d;
      end
      busy <= busy_d;
    end
  end

  for (genvar g = 0; g < NMODES; g++) begin : g_chk
    p_coord_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (coord[g] < extent[g]));
  end

  p_open_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (coord == '0));

  p_hold_without_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> $stable(coord));

endmodule

// File: rtl/layout_affine.sv
module layout_affine #(
  parameter int NMODES = 4,
  parameter int CW     = 16,
  parameter int AW     = 32
) (
  input  logic [NMODES-1:0][CW-1:0] coord,
  input  logic [NMODES-1:0][AW-1:0] stride,
  input  logic [1:0]                esize,
  output logic [AW-1:0]             byte_off
);
  import layout_pkg::*;

  logic [NMODES-1:0][AW-1:0] term;
  logic [AW-1:0]             elem_off;

  for (genvar g = 0; g < NMODES; g++) begin : g_term
    assign term[g] = AW'(coord[g]) * stride[g];
  end

  always_comb begin
    elem_off = '0;
    for (int i = 0; i < NMODES; i++) begin
      elem_off = elem_off + term[i];
    end
  end

  assign byte_off = elem_off << esize_shamt(esize);

endmodule

// File: rtl/layout_swizzle.sv
module layout_swizzle #(
  parameter int AW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  layout_pkg::swz_cfg_t  cfg,
  input  logic [AW-1:0]         addr_in,
  output logic [AW-1:0]         addr_out
);

  logic [5:0]    src_pos;
  logic [AW-1:0] field_mask;
  logic [AW-1:0] field;
  logic [AW-1:0] keep_mask;

  assign src_pos    = {1'b0, cfg.base} + {1'b0, cfg.shift};
  assign field_mask = (AW'(1) << cfg.bits) - AW'(1);
  assign field      = (addr_in >> src_pos) & field_mask;
  assign addr_out   = addr_in ^ (field << cfg.base);
  assign keep_mask  = ~(field_mask << cfg.base);

  p_swz_field_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (((addr_out ^ addr_in) & keep_mask) == '0));

  p_swz_off_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg.bits == 3'd0) |-> (addr_out == addr_in));

endmodule

// File: rtl/layout_addr_gen.sv
module layout_addr_gen #(
  parameter int NMODES = 4,
  parameter int CW     = 16,
  parameter int AW     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NMODES-1:0][CW-1:0]   cfg_extent,
  input  logic [NMODES-1:0][AW-1:0]   cfg_stride,
  input  logic [1:0]                  cfg_esize,
  input  logic [2:0]                  cfg_swz_bits,
  input  logic [4:0]                  cfg_swz_base,
  input  logic [4:0]                  cfg_swz_shift,
  input  logic                        start,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [AW-1:0]               out_offset,
  output logic [NMODES-1:0][CW-1:0]   out_coord,
  output logic                        done
);
  import layout_pkg::*;

  logic [NMODES-1:0][CW-1:0] ext_q, ext_d;
  logic [NMODES-1:0][AW-1:0] stride_q;
  logic [1:0]                esize_q;
  swz_cfg_t                  swz_q, swz_d;
  logic                      done_q, done_d;

  logic                      busy;
  logic                      last;
  logic                      load;
  logic                      advance;
  logic [NMODES-1:0][CW-1:0] coord;
  logic [AW-1:0]             lin_byte;

  assign load    = start && !busy;
  assign advance = busy && out_ready;

  always_comb begin
    for (int i = 0; i < NMODES; i++) begin
      ext_d[i] = (cfg_extent[i] == '0) ? CW'(1) : cfg_extent[i];
    end
    swz_d.bits  = cfg_swz_bits;
    swz_d.base  = cfg_swz_base;
    swz_d.shift = cfg_swz_shift;
    done_d = done_q;
    if (load) begin
      done_d = 1'b0;
    end else if (advance && last) begin
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q    <= '0;
      stride_q <= '0;
      esize_q  <= '0;
      swz_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      if (load) begin
        ext_q    <= ext_d;
        stride_q <= cfg_stride;
        esize_q  <= cfg_esize;
        swz_q    <= swz_d;
      end
      done_q <= done_d;
    end
  end

  layout_odometer #(.NMODES(NMODES), .CW(CW)) odo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (load),
    .advance (advance),
    .extent  (ext_q),
    .coord   (coord),
    .busy    (busy),
    .last    (last)
  );

  layout_affine #(.NMODES(NMODES), .CW(CW), .AW(AW)) aff_i (
    .coord    (coord),
    .stride   (stride_q),
    .esize    (esize_q),
    .byte_off (lin_byte)
  );

  layout_swizzle #(.AW(AW)) swz_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (busy),
    .cfg      (swz_q),
    .addr_in  (lin_byte),
    .addr_out (out_offset)
  );

  assign out_valid = busy;
  assign out_coord = coord;
  assign done      = done_q;

  p_done_not_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) && $stable(out_coord)));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start) |=> ($stable(stride_q) && $stable(ext_q) && $stable(swz_q)));

endmodule

// File: tb/layout_addr_gen_tb.sv
module layout_addr_gen_tb_top;

  localparam int NM = 4;
  localparam int CW = 16;
  localparam int AW = 32;

  logic                   clk;
  logic                   rst_n;
  logic [NM-1:0][CW-1:0]  cfg_extent;
  logic [NM-1:0][AW-1:0]  cfg_stride;
  logic [1:0]             cfg_esize;
  logic [2:0]             cfg_swz_bits;
  logic [4:0]             cfg_swz_base;
  logic [4:0]             cfg_swz_shift;
  logic                   start;
  logic                   out_valid;
  logic                   out_ready;
  logic [AW-1:0]          out_offset;
  logic [NM-1:0][CW-1:0]  out_coord;
  logic                   done;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  logic [31:0] tab [8][64];

  layout_addr_gen #(.NMODES(NM), .CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_extent(cfg_extent), .cfg_stride(cfg_stride),
    .cfg_esize(cfg_esize), .cfg_swz_bits(cfg_swz_bits), .cfg_swz_base(cfg_swz_base),
    .cfg_swz_shift(cfg_swz_shift), .start(start), .out_valid(out_valid),
    .out_ready(out_ready), .out_offset(out_offset), .out_coord(out_coord), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5ns * 150000);
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_off(input logic [NM-1:0][CW-1:0] c,
      input logic [NM-1:0][31:0] st, input logic [1:0] esz,
      input int b, input int m, input int s);
    logic [31:0] lin, byt, fld;
    lin = 0;
    for (int i = 0; i < NM; i++) lin = lin + 32'(c[i]) * st[i];
    byt = lin * ((esz == 2'd0) ? 32'd1 : (esz == 2'd1) ? 32'd2 : 32'd4);
    fld = (byt >> (m + s)) & ((32'd1 << b) - 32'd1);
    return byt ^ (fld << m);
  endfunction

  function automatic bit rdy_pat(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 0;
      default: return (c % 5) < 2;
    endcase
  endfunction

  task automatic run_case(input string tag,
      input logic [NM-1:0][CW-1:0] e, input logic [NM-1:0][31:0] st,
      input logic [1:0] esz, input int b, input int m, input int s,
      input int rmode, input bit disturb, input bit bankchk);
    int ee [NM];
    int idx;
    bit stalled;
    bit disturbed;
    logic [31:0] hold_off;
    logic [NM-1:0][CW-1:0] hold_c;
    logic [NM-1:0][CW-1:0] ec;
    logic [31:0] eo;
    for (int i = 0; i < NM; i++) ee[i] = (e[i] == 0) ? 1 : int'(e[i]);
    @(negedge clk);
    cfg_extent = e; cfg_stride = st; cfg_esize = esz;
    cfg_swz_bits = 3'(b); cfg_swz_base = 5'(m); cfg_swz_shift = 5'(s);
    out_ready = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    // R7: valid rises with coordinate zero one cycle after start
    check(out_valid == 1'b1 && out_coord == '0, {tag, " R7 open"}, {out_valid, 16'(out_coord)}, 64'h1_0000);
    idx = 0; stalled = 0; disturbed = 0;
    for (int i3 = 0; i3 < ee[3]; i3++)
      for (int i2 = 0; i2 < ee[2]; i2++)
        for (int i1 = 0; i1 < ee[1]; i1++)
          for (int i0 = 0; i0 < ee[0]; i0++) begin
            ec = '0;
            ec[0] = CW'(i0); ec[1] = CW'(i1); ec[2] = CW'(i2); ec[3] = CW'(i3);
            eo = exp_off(ec, st, esz, b, m, s);
            forever begin
              @(negedge clk);
              cyc++;
              start = 1'b0;
              if (disturb && idx == 3 && !disturbed) begin
                // R9: start and config change mid-walk must have no effect
                start = 1'b1;
                cfg_stride = '1;
                cfg_extent = '1;
                cfg_swz_bits = 3'd5;
                disturbed = 1;
              end
              out_ready = rdy_pat(rmode, cyc);
              #1;
              if (stalled)
                check(out_offset == hold_off && out_coord == hold_c, {tag, " R6 stall hold"},
                      64'(out_offset), 64'(hold_off));
              if (!out_valid) begin
                check(1'b0, {tag, " R6 valid dropped"}, 64'(out_valid), 64'd1);
                break;
              end
              if (out_ready) begin
                stalled = 0;
                break;
              end
              stalled = 1; hold_off = out_offset; hold_c = out_coord;
            end
            // R1 R2 R3 R4 R5: offset and visit order
            check(out_coord == ec, {tag, " R2 order"}, 64'(out_coord), 64'(ec));
            check(out_offset == eo, {tag, " R1 offset"}, 64'(out_offset), 64'(eo));
            if (bankchk) tab[i1][i0] = out_offset;
            idx++;
          end
    @(negedge clk);
    start = 1'b0; out_ready = 1'b0;
    #1;
    check(done == 1'b1 && out_valid == 1'b0, {tag, " R8 done"}, {done, out_valid}, 64'h2);
    @(negedge clk);
    #1;
    check(done == 1'b1, {tag, " R8 done held"}, 64'(done), 64'd1);
  endtask

  initial begin
    logic [NM-1:0][CW-1:0] e;
    logic [NM-1:0][31:0] st;
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    cfg_extent = '0; cfg_stride = '0; cfg_esize = '0;
    cfg_swz_bits = '0; cfg_swz_base = '0; cfg_swz_shift = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0 && done == 1'b0, "R10 reset", {out_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0 && done == 1'b0, "R10 idle", {out_valid, done}, 64'd0);

    // row-major 4x4: (row 3, col 3) -> 15
    e = '0; st = '0;
    e[0] = 4; st[0] = 1; e[1] = 4; st[1] = 4; e[2] = 1; e[3] = 1;
    run_case("rowmajor", e, st, 2'd0, 0, 0, 0, 0, 0, 0);
    check(exp_off({16'd0, 16'd0, 16'd3, 16'd3}, st, 2'd0, 0, 0, 0) == 32'd15, "R1 4x4 corner", 64'd15, 64'd15);

    // transposed view: only the strides swap
    e = '0; st = '0;
    e[0] = 4; st[0] = 4; e[1] = 3; st[1] = 1; e[2] = 1; e[3] = 1;
    run_case("transpose", e, st, 2'd0, 0, 0, 0, 1, 0, 0);

    // 8x8 tiled into 2x4 tiles, with a disturbance mid-walk
    e = '0; st = '0;
    e[0] = 4; st[0] = 1; e[1] = 2; st[1] = 4; e[2] = 2; st[2] = 8; e[3] = 4; st[3] = 16;
    run_case("tiled", e, st, 2'd1, 0, 0, 0, 2, 1, 0);

    // R3: inert extent-1 mode and zero extent, with garbage strides there
    e = '0; st = '0;
    e[0] = 3; st[0] = 7; e[1] = 0; st[1] = 999; e[2] = 5; st[2] = 2; e[3] = 1; st[3] = 12345;
    run_case("R3 inert", e, st, 2'd2, 2, 3, 4, 1, 0, 0);

    // R4 R11: 128-byte swizzle over an 8x64 tile of 2-byte elements
    e = '0; st = '0;
    e[0] = 64; st[0] = 1; e[1] = 8; st[1] = 64; e[2] = 1; e[3] = 1;
    run_case("R4 swz128", e, st, 2'd1, 3, 4, 3, 1, 0, 1);
    for (int c = 0; c < 64; c++) begin
      logic [31:0] seen;
      int hits;
      seen = '0; hits = 0;
      for (int r = 0; r < 8; r++) begin
        int bk;
        bk = int'((tab[r][c] >> 2) & 32'd31);
        if (!seen[bk]) hits++;
        seen[bk] = 1'b1;
      end
      check(hits == 8, "R11 distinct banks", 64'(hits), 64'd8);
    end

    // four active modes, 4-byte code 3, 32-bit wrap through a huge stride
    e = '0; st = '0;
    e[0] = 3; st[0] = 5; e[1] = 2; st[1] = 17; e[2] = 4; st[2] = 100; e[3] = 2; st[3] = 32'h8000_0001;
    run_case("R2 fullodo", e, st, 2'd3, 0, 0, 0, 2, 0, 0);

    // R5: wide swizzle field on a longer stride pattern
    e = '0; st = '0;
    e[0] = 16; st[0] = 3; e[1] = 6; st[1] = 40; e[2] = 1; e[3] = 1;
    run_case("R5 swzwide", e, st, 2'd0, 5, 2, 6, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule